// File: doc/BRIEF.md
# Stack Pointer and Context-Save Sequencer

This block owns the stack pointer of a small 8-bit processor core. It also moves register contents between the core and a byte-wide RAM port whenever the program saves or recovers context. The pointer is 16 bits wide on the bus, but only its seven low bits can change. The upper nine bits are tied so that the stack always occupies the 128-byte window 0180h to 01FFh. When the pointer runs past either end of the window it wraps silently, and no flag is raised.

The core drives one strobe per operation:
- subroutine call and return;
- interrupt entry and interrupt return;
- single-byte push and single-byte pop;
- stack reset;
- direct load of the pointer's low byte.

A strobe is sampled on a rising clock edge only while the block is idle. The block then makes one RAM access per clock cycle, starting in the next cycle. A call saves two bytes of the program counter. An interrupt entry saves a fixed five-byte frame that holds the program counter, X, A and the condition codes. The return commands read those bytes back and present the recovered values on their own outputs. A one-cycle `done` pulse follows the last access of every RAM sequence.

Top module: `stk_ctx_seq`

## Requirements
- R1: After reset `sp` reads 01FFh. `ram_we`, `ram_re`, `busy` and `done` are 0, and `pc_out`, `a_out`, `x_out`, `cc_out` and `pop_data` read 0.
- R2: The nine upper bits of `sp` always read 0000_0001_1b. A load command sets the seven low pointer bits from bits 6:0 of `sp_load_val` and discards bit 7.
- R3: A write cycle stores its byte at the address in `sp` and then lowers the pointer by one. A read cycle raises the pointer by one and then reads from the raised address. Exactly one access happens per cycle, and the first access comes in the cycle after the command is sampled.
- R4: Lowering the pointer from 0180h yields 01FFh. Raising it from 01FFh yields 0180h.
- R5: A call writes the PC low byte first and the PC high byte second. A return reads the PC high byte first, then the low byte, and presents the result on `pc_out`.
- R6: Interrupt entry writes five bytes in this order: PC low, PC high, X, A, CC. Interrupt return reads them in the reverse order and presents them on `cc_out`, `a_out`, `x_out` and `pc_out`. No other register is saved.
- R7: `busy` is high exactly in the access cycles of a sequence. `done` is high for the single cycle after the last access, and the recovered outputs are valid in that cycle.
- R8: Any strobe sampled while `busy` is high has no effect on the pointer, on the RAM accesses or on the outputs.
- R9: A stack-reset command sampled while idle sets `sp` to 01FFh in the next cycle, without any RAM access.
- R10: When several strobes are sampled together, exactly one is obeyed. The order, highest first, is: stack reset, load, interrupt entry, call, interrupt return, return, push, pop.
- R11: A single pop presents the byte it reads on `pop_data`. A single push writes `push_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_call | input | 1 | Start a subroutine-call save |
| cmd_ret | input | 1 | Start a subroutine-return restore |
| cmd_irq | input | 1 | Start an interrupt-entry save |
| cmd_iret | input | 1 | Start an interrupt-return restore |
| cmd_push | input | 1 | Push one byte |
| cmd_pop | input | 1 | Pop one byte |
| cmd_sp_reset | input | 1 | Return the pointer to the top of the window |
| cmd_sp_load | input | 1 | Load the pointer's low byte |
| sp_load_val | input | 8 | Value for the load command; bits 6:0 are used |
| pc_in | input | 16 | Program counter to save |
| a_in | input | 8 | Accumulator to save |
| x_in | input | 8 | X index register to save |
| cc_in | input | 8 | Condition codes to save |
| push_data | input | 8 | Byte for a single push |
| ram_rdata | input | 8 | RAM read data, valid in the same cycle as the address |
| ram_addr | output | 16 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| sp | output | 16 | Current stack pointer |
| pc_out | output | 16 | Recovered program counter |
| a_out | output | 8 | Recovered accumulator |
| x_out | output | 8 | Recovered X register |
| cc_out | output | 8 | Recovered condition codes |
| pop_data | output | 8 | Byte read by a single pop |
| busy | output | 1 | A RAM sequence is in progress |
| done | output | 1 | One-cycle pulse after the last access |

## Verification
Almost every internal fault in this block reaches a port within one cycle. A wrong pointer shows on `sp` and on `ram_addr` at the next access. A wrong frame index puts a misplaced byte on `ram_wdata`, or a misrouted byte on a recovered output, in the `done` cycle. A broken length count shifts `done` and `busy`, and the next command then lands out of step. The reference model tracks the pointer, the stored bytes and the frame order on its own terms. It is compared against the ports on every clock, including across both window boundaries and while strobes arrive during a sequence.

// File: rtl/stk_pkg.sv
package stk_pkg;

    // Width of the frame byte index and the largest frame length.
    localparam int IDX_W     = 3;
    localparam int FRAME_LEN = 5;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_CALL = 3'd1,
        OP_RET  = 3'd2,
        OP_IRQ  = 3'd3,
        OP_IRET = 3'd4,
        OP_PUSH = 3'd5,
        OP_POP  = 3'd6
    } stk_op_e;

    // Index of the final access of each sequence.
    function automatic logic [IDX_W-1:0] op_last(input stk_op_e op);
        case (op)
            OP_CALL, OP_RET:  return IDX_W'(1);
            OP_IRQ, OP_IRET:  return IDX_W'(FRAME_LEN - 1);
            default:          return '0;
        endcase
    endfunction

    // Sequences that store to RAM, as opposed to those that read it.
    function automatic logic op_writes(input stk_op_e op);
        return (op == OP_CALL) || (op == OP_IRQ) || (op == OP_PUSH);
    endfunction

endpackage

// File: rtl/stk_ptr_step.sv
// Next-value arithmetic for the movable part of the stack pointer.
// Modular arithmetic on WIN_W bits gives the wrap at both ends.
module stk_ptr_step #(
    parameter int WIN_W  = 7,
    parameter int DATA_W = 8
) (
    input  logic [WIN_W-1:0]  ptr_q,
    input  logic [DATA_W-1:0] load_val,
    output logic [WIN_W-1:0]  ptr_inc,
    output logic [WIN_W-1:0]  ptr_dec,
    output logic [WIN_W-1:0]  ptr_load,
    output logic [WIN_W-1:0]  ptr_top
);
    logic unused_load_hi;

    assign ptr_inc        = ptr_q + WIN_W'(1);
    assign ptr_dec        = ptr_q - WIN_W'(1);
    assign ptr_load       = load_val[WIN_W-1:0];
    assign ptr_top        = '1;
    assign unused_load_hi = ^load_val[DATA_W-1:WIN_W];
endmodule

// File: rtl/stk_byte_pick.sv
// Selects the byte written in a given cycle of a save sequence.
module stk_byte_pick
    import stk_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  stk_op_e           op,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] pcl,
    input  logic [DATA_W-1:0] pch,
    input  logic [DATA_W-1:0] xv,
    input  logic [DATA_W-1:0] av,
    input  logic [DATA_W-1:0] ccv,
    input  logic [DATA_W-1:0] single,
    output logic [DATA_W-1:0] wbyte
);
    always_comb begin
        if (op == OP_PUSH) begin
            wbyte = single;
        end else begin
            case (idx)
                IDX_W'(0): wbyte = pcl;
                IDX_W'(1): wbyte = pch;
                IDX_W'(2): wbyte = xv;
                IDX_W'(3): wbyte = av;
                default:   wbyte = ccv;
            endcase
        end
    end
endmodule

// File: rtl/stk_ctx_seq.sv
module stk_ctx_seq
    import stk_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter int          WIN_W    = 7,
    parameter int unsigned WIN_BASE = 'h180
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_call,
    input  logic                cmd_ret,
    input  logic                cmd_irq,
    input  logic                cmd_iret,
    input  logic                cmd_push,
    input  logic                cmd_pop,
    input  logic                cmd_sp_reset,
    input  logic                cmd_sp_load,
    input  logic [DATA_W-1:0]   sp_load_val,
    input  logic [2*DATA_W-1:0] pc_in,
    input  logic [DATA_W-1:0]   a_in,
    input  logic [DATA_W-1:0]   x_in,
    input  logic [DATA_W-1:0]   cc_in,
    input  logic [DATA_W-1:0]   push_data,
    input  logic [DATA_W-1:0]   ram_rdata,
    output logic [ADDR_W-1:0]   ram_addr,
    output logic [DATA_W-1:0]   ram_wdata,
    output logic                ram_we,
    output logic                ram_re,
    output logic [ADDR_W-1:0]   sp,
    output logic [2*DATA_W-1:0] pc_out,
    output logic [DATA_W-1:0]   a_out,
    output logic [DATA_W-1:0]   x_out,
    output logic [DATA_W-1:0]   cc_out,
    output logic [DATA_W-1:0]   pop_data,
    output logic                busy,
    output logic                done
);
    localparam int                HI_W    = ADDR_W - WIN_W;
    localparam logic [HI_W-1:0]   HI_BITS = HI_W'(WIN_BASE >> WIN_W);

    typedef struct packed {
        stk_op_e              op;
        logic [IDX_W-1:0]     idx;
        logic [WIN_W-1:0]     ptr;
        logic [DATA_W-1:0]    cap_pcl;
        logic [DATA_W-1:0]    cap_pch;
        logic [DATA_W-1:0]    cap_x;
        logic [DATA_W-1:0]    cap_a;
        logic [DATA_W-1:0]    cap_cc;
        logic [DATA_W-1:0]    cap_push;
        logic [2*DATA_W-1:0]  pc_r;
        logic [DATA_W-1:0]    a_r;
        logic [DATA_W-1:0]    x_r;
        logic [DATA_W-1:0]    cc_r;
        logic [DATA_W-1:0]    pop_r;
        logic                 done;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        op: OP_NONE, idx: '0, ptr: '1,
        cap_pcl: '0, cap_pch: '0, cap_x: '0, cap_a: '0, cap_cc: '0, cap_push: '0,
        pc_r: '0, a_r: '0, x_r: '0, cc_r: '0, pop_r: '0, done: 1'b0
    };

    seq_t q, d;

    logic [WIN_W-1:0]  ptr_inc, ptr_dec, ptr_load, ptr_top;
    logic [DATA_W-1:0] wr_byte;
    logic              active;

    stk_ptr_step #(.WIN_W(WIN_W), .DATA_W(DATA_W)) u_step (
        .ptr_q    (q.ptr),
        .load_val (sp_load_val),
        .ptr_inc  (ptr_inc),
        .ptr_dec  (ptr_dec),
        .ptr_load (ptr_load),
        .ptr_top  (ptr_top)
    );

    stk_byte_pick #(.DATA_W(DATA_W)) u_pick (
        .op     (q.op),
        .idx    (q.idx),
        .pcl    (q.cap_pcl),
        .pch    (q.cap_pch),
        .xv     (q.cap_x),
        .av     (q.cap_a),
        .ccv    (q.cap_cc),
        .single (q.cap_push),
        .wbyte  (wr_byte)
    );

    assign active = (q.op != OP_NONE);

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        ram_addr  = {HI_BITS, q.ptr};
        ram_wdata = '0;
        ram_we    = 1'b0;
        ram_re    = 1'b0;

        if (!active) begin
            // Capture the context on every idle cycle; only a start uses it.
            d.cap_pcl  = pc_in[DATA_W-1:0];
            d.cap_pch  = pc_in[2*DATA_W-1:DATA_W];
            d.cap_x    = x_in;
            d.cap_a    = a_in;
            d.cap_cc   = cc_in;
            d.cap_push = push_data;
            d.idx      = '0;
            if (cmd_sp_reset)      d.ptr = ptr_top;
            else if (cmd_sp_load)  d.ptr = ptr_load;
            else if (cmd_irq)      d.op  = OP_IRQ;
            else if (cmd_call)     d.op  = OP_CALL;
            else if (cmd_iret)     d.op  = OP_IRET;
            else if (cmd_ret)      d.op  = OP_RET;
            else if (cmd_push)     d.op  = OP_PUSH;
            else if (cmd_pop)      d.op  = OP_POP;
        end else begin
            if (op_writes(q.op)) begin
                ram_we    = 1'b1;
                ram_wdata = wr_byte;
                d.ptr     = ptr_dec;
            end else begin
                ram_re   = 1'b1;
                ram_addr = {HI_BITS, ptr_inc};
                d.ptr    = ptr_inc;
                case (q.op)
                    OP_RET: begin
                        if (q.idx == '0) d.pc_r[2*DATA_W-1:DATA_W] = ram_rdata;
                        else             d.pc_r[DATA_W-1:0]        = ram_rdata;
                    end
                    OP_IRET: begin
                        case (q.idx)
                            IDX_W'(0): d.cc_r = ram_rdata;
                            IDX_W'(1): d.a_r  = ram_rdata;
                            IDX_W'(2): d.x_r  = ram_rdata;
                            IDX_W'(3): d.pc_r[2*DATA_W-1:DATA_W] = ram_rdata;
                            default:   d.pc_r[DATA_W-1:0]        = ram_rdata;
                        endcase
                    end
                    default: d.pop_r = ram_rdata;
                endcase
            end
            if (q.idx == op_last(q.op)) begin
                d.op   = OP_NONE;
                d.done = 1'b1;
            end else begin
                d.idx = q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RST;
        else        q <= d;
    end

    assign sp       = {HI_BITS, q.ptr};
    assign pc_out   = q.pc_r;
    assign a_out    = q.a_r;
    assign x_out    = q.x_r;
    assign cc_out   = q.cc_r;
    assign pop_data = q.pop_r;
    assign busy     = active;
    assign done     = q.done;
endmodule

// File: rtl/stk_ctx_seq_chk.sv
module stk_ctx_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int WIN_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              ram_we,
    input logic              ram_re,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [ADDR_W-1:0] sp,
    input logic              cmd_sp_reset
);
    // R3
    ptr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> (sp[WIN_W-1:0] == $past(sp[WIN_W-1:0]) - WIN_W'(1)));

    // R3
    ptr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_re |=> (sp[WIN_W-1:0] == $past(sp[WIN_W-1:0]) + WIN_W'(1)));

    // R3
    read_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_re |-> (ram_addr[WIN_W-1:0] == sp[WIN_W-1:0] + WIN_W'(1)));

    // R3
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    sp_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_sp_reset) |=> (sp[WIN_W-1:0] == '1));
endmodule

bind stk_ctx_seq stk_ctx_seq_chk #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .done         (done),
    .ram_we       (ram_we),
    .ram_re       (ram_re),
    .ram_addr     (ram_addr),
    .sp           (sp),
    .cmd_sp_reset (cmd_sp_reset)
);

// File: tb/stk_ctx_seq_tb.sv
`timescale 1ns/1ps
module stk_ctx_seq_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic c_call = 0, c_ret = 0, c_irq = 0, c_iret = 0, c_push = 0, c_pop = 0, c_rst = 0, c_ld = 0;
    logic [7:0]  ld_val = 0, a_in = 0, x_in = 0, cc_in = 0, push_data = 0;
    logic [15:0] pc_in = 0;
    logic [7:0]  ram_rdata, ram_wdata, a_out, x_out, cc_out, pop_data;
    logic [15:0] ram_addr, sp, pc_out;
    logic        ram_we, ram_re, busy, done;

    always #2.5 clk = ~clk;

    stk_ctx_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_call(c_call), .cmd_ret(c_ret), .cmd_irq(c_irq), .cmd_iret(c_iret),
        .cmd_push(c_push), .cmd_pop(c_pop), .cmd_sp_reset(c_rst), .cmd_sp_load(c_ld),
        .sp_load_val(ld_val), .pc_in(pc_in), .a_in(a_in), .x_in(x_in), .cc_in(cc_in),
        .push_data(push_data), .ram_rdata(ram_rdata), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_re(ram_re), .sp(sp),
        .pc_out(pc_out), .a_out(a_out), .x_out(x_out), .cc_out(cc_out),
        .pop_data(pop_data), .busy(busy), .done(done)
    );

    // RAM model with read data available in the addressed cycle
    logic [7:0] ram_mem [0:511];
    always @(posedge clk) if (ram_we) ram_mem[ram_addr[8:0]] <= ram_wdata;
    assign ram_rdata = ram_mem[ram_addr[8:0]];

    // Reference model state
    typedef struct {
        bit          wr;
        bit          rd;
        bit          dn;
        logic [15:0] addr;
        logic [15:0] spv;
        logic [7:0]  wd;
        string       req;
    } exp_t;
    exp_t        exq[$];
    int          sp_m = 127;
    logic [7:0]  ref_mem [0:511];
    logic [15:0] pc_m = 0;
    logic [7:0]  a_m = 0, x_m = 0, cc_m = 0, pd_m = 0;
    string       cur_req = "R1";
    bit          m_busy = 0;
    int          vec = 0, bad = 0;

    function automatic logic [15:0] full(int p);
        return 16'h0180 + 16'(p);
    endfunction

    function automatic void cmp(string r, string what, logic [15:0] act, logic [15:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
        end
    endfunction

    function automatic void m_wr(logic [7:0] b);
        exp_t e;
        e.wr = 1; e.rd = 0; e.dn = 0; e.wd = b; e.req = cur_req;
        e.addr = full(sp_m); e.spv = full(sp_m);
        ref_mem[e.addr[8:0]] = b;
        sp_m = (sp_m + 127) % 128;
        exq.push_back(e);
    endfunction

    function automatic logic [7:0] m_rd();
        exp_t e;
        e.wr = 0; e.rd = 1; e.dn = 0; e.wd = 0; e.req = cur_req;
        e.spv = full(sp_m);
        sp_m = (sp_m + 1) % 128;
        e.addr = full(sp_m);
        exq.push_back(e);
        return ref_mem[e.addr[8:0]];
    endfunction

    function automatic void m_fin();
        exp_t e;
        e.wr = 0; e.rd = 0; e.dn = 1; e.wd = 0; e.req = cur_req;
        e.addr = 0; e.spv = full(sp_m);
        exq.push_back(e);
    endfunction

    // Priority R10: reset, load, irq, call, iret, ret, push, pop
    function automatic void accept();
        if (c_rst)       sp_m = 127;
        else if (c_ld)   sp_m = int'(ld_val) % 128;
        else if (c_irq)  begin m_wr(pc_in[7:0]); m_wr(pc_in[15:8]); m_wr(x_in); m_wr(a_in); m_wr(cc_in); m_fin(); end
        else if (c_call) begin m_wr(pc_in[7:0]); m_wr(pc_in[15:8]); m_fin(); end
        else if (c_iret) begin cc_m = m_rd(); a_m = m_rd(); x_m = m_rd(); pc_m[15:8] = m_rd(); pc_m[7:0] = m_rd(); m_fin(); end
        else if (c_ret)  begin pc_m[15:8] = m_rd(); pc_m[7:0] = m_rd(); m_fin(); end
        else if (c_push) begin m_wr(push_data); m_fin(); end
        else if (c_pop)  begin pd_m = m_rd(); m_fin(); end
    endfunction

    task automatic tick();
        exp_t e;
        @(negedge clk);
        if (exq.size() > 0) e = exq.pop_front();
        else begin
            e.wr = 0; e.rd = 0; e.dn = 0; e.addr = 0; e.wd = 0;
            e.spv = full(sp_m); e.req = cur_req;
        end
        cmp("R7", "busy", 16'(busy), 16'(e.wr | e.rd));
        cmp("R7", "done", 16'(done), 16'(e.dn));
        cmp(e.req, "ram_we", 16'(ram_we), 16'(e.wr));
        cmp(e.req, "ram_re", 16'(ram_re), 16'(e.rd));
        cmp(e.req, "sp", sp, e.spv);
        if (e.wr | e.rd) cmp(e.req, "ram_addr", ram_addr, e.addr);
        if (e.wr) cmp(e.req, "ram_wdata", 16'(ram_wdata), 16'(e.wd));
        if (!(e.wr | e.rd)) begin
            cmp(e.req, "pc_out", pc_out, pc_m);
            cmp(e.req, "a_out", 16'(a_out), 16'(a_m));
            cmp(e.req, "x_out", 16'(x_out), 16'(x_m));
            cmp(e.req, "cc_out", 16'(cc_out), 16'(cc_m));
            cmp(e.req, "pop_data", 16'(pop_data), 16'(pd_m));
        end
        m_busy = e.wr | e.rd;
    endtask

    task automatic drive(bit rs, bit ld, bit irq, bit call, bit iret, bit ret, bit ps, bit pp);
        c_rst = rs; c_ld = ld; c_irq = irq; c_call = call;
        c_iret = iret; c_ret = ret; c_push = ps; c_pop = pp;
        if (!m_busy) accept();
        tick();
        c_rst = 0; c_ld = 0; c_irq = 0; c_call = 0;
        c_iret = 0; c_ret = 0; c_push = 0; c_pop = 0;
    endtask

    task automatic drain();
        while (exq.size() > 0) tick();
        tick();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    endtask

    initial begin
        #100000;
        bad++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        for (int i = 0; i < 512; i++) begin ram_mem[i] = 8'h00; ref_mem[i] = 8'h00; end
        // R1: reset state
        cur_req = "R1";
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();

        // R3 / R11: single push then pop
        cur_req = "R3"; push_data = 8'h11;
        drive(0,0,0,0,0,0,1,0); drain();
        cur_req = "R11";
        drive(0,0,0,0,0,0,0,1); drain();

        // R5: call and return
        cur_req = "R5"; pc_in = 16'h1234;
        drive(0,0,0,1,0,0,0,0); drain();
        pc_in = 16'h0000;
        drive(0,0,0,0,0,1,0,0); drain();

        // R6: interrupt entry and return
        cur_req = "R6"; pc_in = 16'hABCD; x_in = 8'h5A; a_in = 8'hC3; cc_in = 8'h0E;
        drive(0,0,1,0,0,0,0,0); drain();
        pc_in = 0; x_in = 0; a_in = 0; cc_in = 0;
        drive(0,0,0,0,1,0,0,0); drain();

        // R8: strobes during a sequence are ignored
        cur_req = "R8"; pc_in = 16'h2468; x_in = 8'h01; a_in = 8'h02; cc_in = 8'h03;
        ld_val = 8'h10;
        drive(0,0,1,0,0,0,0,0);
        drive(1,1,0,1,1,1,1,1);
        drive(0,0,0,1,0,0,0,0);
        drain();
        drive(0,0,0,0,1,0,0,0); drain();

        // R2: only bits 6:0 of the load value matter
        cur_req = "R2"; ld_val = 8'h85;
        drive(0,1,0,0,0,0,0,0); tick();

        // R4: wrap both directions
        cur_req = "R4"; ld_val = 8'h00;
        drive(0,1,0,0,0,0,0,0); tick();
        push_data = 8'h77;
        drive(0,0,0,0,0,0,1,0); drain();
        drive(0,0,0,0,0,0,0,1); drain();
        ld_val = 8'h02;
        drive(0,1,0,0,0,0,0,0); tick();
        pc_in = 16'h55AA; x_in = 8'h3C; a_in = 8'h96; cc_in = 8'h81;
        drive(0,0,1,0,0,0,0,0); drain();
        drive(0,0,0,0,1,0,0,0); drain();

        // R9: stack reset
        cur_req = "R9"; ld_val = 8'h40;
        drive(0,1,0,0,0,0,0,0); tick();
        drive(1,0,0,0,0,0,0,0); tick(); tick();

        // R10: simultaneous strobes obey the priority order
        cur_req = "R10"; push_data = 8'hEE;
        drive(1,0,0,0,0,0,1,0); tick();
        pc_in = 16'h0F0F; x_in = 8'h44; a_in = 8'h55; cc_in = 8'h66;
        drive(0,0,1,1,0,0,1,1); drain();
        drive(0,0,0,0,1,1,0,1); drain();

        summary();
    end
endmodule